// File: doc/BRIEF.md
# LWE Single-Bit Encryptor

This block turns one plaintext bit into a learning-with-errors ciphertext pair (u, v) under a public key that arrives one row at a time. Each key row carries N elements of the matrix part and one element of the column part. A per-row random select bit arrives on its own port alongside the row. A selected row is added lane by lane into the vector accumulator u, and its column element is added into the scalar accumulator v. A row that is not selected is dropped at once, so the key is never stored inside the block.

Every addition is reduced modulo q as it happens. When the final row has been taken in, v receives an offset of floor(q/2), formed by a one-place right shift of q, if the message bit is 1. The sum is again reduced modulo q. The block then emits the N elements of u and, last of all, v, one word per cycle with a valid strobe. It raises ready and holds all outputs still until reset is asserted again.

A controller uses it by holding reset high while it sets q and the message bit. It releases reset, streams the key rows and marks the final one. It then collects N+1 output words. Key elements must already be below q, q must be at least 2, and q and the message bit must stay constant from reset release until ready.

Top module: `lwe_bit_encryptor`

## Requirements
- R1: While rst is high at a clock edge, ready and out_valid are low after that edge.
- R2: Each u element equals the sum, modulo q, of the same lane over all rows that had row_valid and row_sel high. Lane g of a row sits at row_a bits [g*W +: W].
- R3: Before the offset is applied, v equals the sum, modulo q, of row_b over the same selected rows.
- R4: With msg_bit at 1, the emitted v is (B-sum + floor(q/2)) mod q. With msg_bit at 0 it is the B-sum alone.
- R5: A row with row_last high and row_valid high ends collection, and it is itself accumulated if row_sel is high. Inputs in a cycle with row_valid low, including row_sel and row_last, have no effect.
- R6: The output is exactly N+1 words on consecutive cycles with out_valid high: u element 0 first, up to element N-1, and then v. out_last is high only with v.
- R7: In the cycle after the v word, ready goes high and out_valid goes low. Ready, out_word and the absence of valid words then hold until rst, whatever the row inputs do.
- R8: If no row is selected, every u word is 0 and v equals the message offset alone.
- R9: Every emitted word is less than q, including cases where sums wrap past q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high restart; collection begins on the first edge after release |
| msg_bit | input | 1 | Plaintext bit to encrypt |
| q_mod | input | W | Modulus q (at least 2) |
| row_valid | input | 1 | A key row is present this cycle |
| row_sel | input | 1 | Random choice: include this row |
| row_last | input | 1 | This row is the final key row |
| row_a | input | N*W | Matrix row, lane g at bits [g*W +: W] |
| row_b | input | W | Column element of the row |
| out_valid | output | 1 | out_word carries a ciphertext word |
| out_last | output | 1 | The current word is v |
| out_word | output | W | Serial ciphertext word |
| ready | output | 1 | Encryption finished; outputs frozen |

## Verification
Two functions can act in the same cycle. One is the accumulation of a selected row. The other is the end-of-key decision, and both fall in the cycle where the final row is also selected. The bench provokes this directly and in random runs, and judges it by whether that row's contribution shows in u and v. It also places gap cycles whose row_last and row_sel are high while row_valid is low, to confirm that they neither end collection nor accumulate. A second overlap, a modular wrap in the same addition as the message offset, is provoked with B-sums near q-1 and a large q.

// File: rtl/lwe_enc_pkg.sv
package lwe_enc_pkg;
    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_OFFSET  = 2'd1,
        ST_EMIT    = 2'd2,
        ST_DONE    = 2'd3
    } enc_state_e;
endpackage

// File: rtl/lwe_mod_add.sv
// Modular adder: both operands must already be below q.
module lwe_mod_add #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] q,
    output logic [W-1:0] s
);
    logic [W:0] raw;
    logic [W:0] folded;

    always_comb begin
        raw    = {1'b0, a} + {1'b0, b};
        folded = raw - {1'b0, q};
        s      = (raw >= {1'b0, q}) ? folded[W-1:0] : raw[W-1:0];
    end
endmodule

// File: rtl/lwe_word_pick.sv
// Selects the ciphertext word for a given output index: u lanes, then v.
module lwe_word_pick #(
    parameter int W  = 16,
    parameter int N  = 8,
    parameter int IW = 4
) (
    input  logic [N-1:0][W-1:0] u,
    input  logic [W-1:0]        v,
    input  logic [IW-1:0]       idx,
    output logic [W-1:0]        word
);
    always_comb begin
        word = v;
        for (int i = 0; i < N; i++) begin
            if (idx == IW'(i)) word = u[i];
        end
    end
endmodule

// File: rtl/lwe_bit_encryptor.sv
module lwe_bit_encryptor
    import lwe_enc_pkg::*;
#(
    parameter int W = 16,
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           msg_bit,
    input  logic [W-1:0]   q_mod,
    input  logic           row_valid,
    input  logic           row_sel,
    input  logic           row_last,
    input  logic [N*W-1:0] row_a,
    input  logic [W-1:0]   row_b,
    output logic           out_valid,
    output logic           out_last,
    output logic [W-1:0]   out_word,
    output logic           ready
);
    localparam int IW = $clog2(N + 1);

    typedef struct packed {
        enc_state_e          st;
        logic [N-1:0][W-1:0] u;
        logic [W-1:0]        v;
        logic [IW-1:0]       idx;
        logic                ov;
        logic                ol;
        logic [W-1:0]        od;
        logic                rdy;
    } regs_t;

    regs_t r_q, r_d;

    logic [N-1:0][W-1:0] u_sum;
    logic [W-1:0]        v_sum;
    logic [W-1:0]        v_addend;
    logic [W-1:0]        half_q;
    logic [W-1:0]        picked;

    assign half_q = q_mod >> 1;

    // The v lane adds row_b while collecting and the message offset afterwards.
    assign v_addend = (r_q.st == ST_COLLECT) ? row_b
                    : (msg_bit ? half_q : '0);

    generate
        for (genvar g = 0; g < N; g++) begin : g_lane
            lwe_mod_add #(.W(W)) u_add (
                .a (r_q.u[g]),
                .b (row_a[g*W +: W]),
                .q (q_mod),
                .s (u_sum[g])
            );
        end
    endgenerate

    lwe_mod_add #(.W(W)) v_add (
        .a (r_q.v),
        .b (v_addend),
        .q (q_mod),
        .s (v_sum)
    );

    lwe_word_pick #(.W(W), .N(N), .IW(IW)) pick (
        .u    (r_q.u),
        .v    (r_q.v),
        .idx  (r_q.idx),
        .word (picked)
    );

    always_comb begin
        r_d    = r_q;
        r_d.ov = 1'b0;
        r_d.ol = 1'b0;
        unique case (r_q.st)
            ST_COLLECT: begin
                if (row_valid) begin
                    if (row_sel) begin
                        r_d.u = u_sum;
                        r_d.v = v_sum;
                    end
                    if (row_last) r_d.st = ST_OFFSET;
                end
            end
            ST_OFFSET: begin
                r_d.v   = v_sum;
                r_d.idx = '0;
                r_d.st  = ST_EMIT;
            end
            ST_EMIT: begin
                r_d.ov = 1'b1;
                r_d.od = picked;
                if (r_q.idx == IW'(N)) begin
                    r_d.ol = 1'b1;
                    r_d.st = ST_DONE;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_DONE: begin
                r_d.rdy = 1'b1;
            end
            default: r_d.st = ST_COLLECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign out_valid = r_q.ov;
    assign out_last  = r_q.ol;
    assign out_word  = r_q.od;
    assign ready     = r_q.rdy;
endmodule

// File: rtl/lwe_enc_checker.sv
module lwe_enc_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] q_mod,
    input logic         out_valid,
    input logic         out_last,
    input logic [W-1:0] out_word,
    input logic         ready
);
    // R7
    ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);
    // R7
    frozen_word_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> $stable(out_word));
    // R7
    no_valid_when_ready_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> !out_valid);
    // R6
    last_is_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);
    // R6
    burst_unbroken_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> out_valid);
    // R7
    ready_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        out_last |=> (ready && !out_valid));
    // R9
    word_reduced_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_word < q_mod));
endmodule

bind lwe_bit_encryptor lwe_enc_checker #(.W(W)) enc_chk (
    .clk       (clk),
    .rst       (rst),
    .q_mod     (q_mod),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_word  (out_word),
    .ready     (ready)
);

// File: tb/tb_lwe_bit_encryptor.sv
`timescale 1ns/1ps
module tb_lwe_bit_encryptor;
    localparam int W    = 16;
    localparam int N    = 8;
    localparam int MAXR = 12;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           msg_bit = 1'b0;
    logic [W-1:0]   q_mod = 16'd23;
    logic           row_valid = 1'b0;
    logic           row_sel = 1'b0;
    logic           row_last = 1'b0;
    logic [N*W-1:0] row_a = '0;
    logic [W-1:0]   row_b = '0;
    logic           out_valid, out_last, ready;
    logic [W-1:0]   out_word;

    int n_checks = 0;
    int n_fail   = 0;

    logic [W-1:0] ka [MAXR][N];
    logic [W-1:0] kb [MAXR];
    logic         ks [MAXR];

    always #2.5 clk = ~clk;

    lwe_bit_encryptor #(.W(W), .N(N)) dut (
        .clk(clk), .rst(rst), .msg_bit(msg_bit), .q_mod(q_mod),
        .row_valid(row_valid), .row_sel(row_sel), .row_last(row_last),
        .row_a(row_a), .row_b(row_b),
        .out_valid(out_valid), .out_last(out_last),
        .out_word(out_word), .ready(ready)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic fill(input logic [W-1:0] q, input int pct, input int nrows);
        for (int r = 0; r < nrows; r++) begin
            for (int g = 0; g < N; g++) ka[r][g] = W'($urandom % q);
            kb[r] = W'($urandom % q);
            ks[r] = (($urandom % 100) < pct);
        end
    endtask

    task automatic run_case(input logic [W-1:0] q, input logic msg, input int nrows,
                            input bit gaps, input string req_u);
        longint eu [N];
        longint ev;
        logic [W-1:0] held;
        int wait_n;
        ev = 0;
        for (int g = 0; g < N; g++) eu[g] = 0;
        for (int r = 0; r < nrows; r++) begin
            if (ks[r]) begin
                for (int g = 0; g < N; g++) eu[g] = (eu[g] + ka[r][g]) % q;
                ev = (ev + kb[r]) % q;
            end
        end
        if (msg) ev = (ev + (q >> 1)) % q;

        @(negedge clk);
        rst = 1'b1; row_valid = 1'b0; row_last = 1'b0; q_mod = q; msg_bit = msg;
        @(negedge clk);
        @(negedge clk);
        // R1: held in restart
        check(!ready && !out_valid, "R1 reset state", {ready, out_valid}, 0);
        rst = 1'b0;
        for (int r = 0; r < nrows; r++) begin
            if (gaps && (r % 2 == 0)) begin
                // R5: idle cycle with sel/last high must be ignored
                row_valid = 1'b0; row_sel = 1'b1; row_last = 1'b1;
                row_a = {N{W'($urandom % q)}}; row_b = W'($urandom % q);
                @(negedge clk);
            end
            row_valid = 1'b1; row_sel = ks[r]; row_last = (r == nrows - 1);
            for (int g = 0; g < N; g++) row_a[g*W +: W] = ka[r][g];
            row_b = kb[r];
            @(negedge clk);
        end
        row_valid = 1'b0; row_last = 1'b0; row_sel = 1'b0;
        wait_n = 0;
        while (!out_valid && wait_n < 20) begin
            @(negedge clk);
            wait_n++;
        end
        for (int i = 0; i <= N; i++) begin
            check(out_valid, "R6 valid burst", out_valid, 1);
            check(out_last == (i == N), "R6 last flag", out_last, (i == N));
            if (i < N)
                check(out_word == eu[i], req_u, out_word, eu[i]);
            else
                check(out_word == ev, msg ? "R4 v with offset" : "R3 v sum", out_word, ev);
            check(out_word < q, "R9 reduced", out_word, q);
            @(negedge clk);
        end
        check(ready && !out_valid, "R7 ready after v", {ready, out_valid}, 2);
        held = out_word;
        // R7: row traffic after completion is ignored
        for (int k = 0; k < 3; k++) begin
            row_valid = 1'b1; row_sel = 1'b1; row_last = 1'b1;
            row_a = {N{W'($urandom % q)}}; row_b = W'($urandom % q);
            @(negedge clk);
        end
        row_valid = 1'b0; row_sel = 1'b0; row_last = 1'b0;
        check(ready && !out_valid && out_word == held, "R7 frozen", out_word, held);
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got 0 expected 1 (run finished)");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] q;
        void'($urandom(32'h5EED_1234));
        // R8: nothing selected, message 1 -> only the offset
        fill(16'd23, 0, 5);
        run_case(16'd23, 1'b1, 5, 1'b0, "R8 u zero");
        // R8: nothing selected, message 0 -> all zero
        fill(16'd97, 0, 3);
        run_case(16'd97, 1'b0, 3, 1'b1, "R8 u zero");
        // R2 R3: every row selected, message 0
        fill(16'd23, 100, 6);
        run_case(16'd23, 1'b0, 6, 1'b0, "R2 u sum");
        // R5: only the final row selected
        fill(16'd101, 0, 4);
        ks[3] = 1'b1;
        run_case(16'd101, 1'b1, 4, 1'b1, "R5 last row counted");
        // R5: single row that is also last and selected
        fill(16'd50, 100, 1);
        run_case(16'd50, 1'b1, 1, 1'b0, "R5 single row");
        // smallest modulus
        fill(16'd2, 60, 7);
        run_case(16'd2, 1'b1, 7, 1'b1, "R2 q=2");
        // R9: wrap plus offset near the top of the range
        for (int r = 0; r < MAXR; r++) begin
            for (int g = 0; g < N; g++) ka[r][g] = 16'd65520;
            kb[r] = 16'd65519 - 16'(r);
            ks[r] = 1'b1;
        end
        run_case(16'd65521, 1'b1, MAXR, 1'b0, "R9 wrap u");
        // random runs
        for (int t = 0; t < 24; t++) begin
            int nr;
            q  = W'(2 + ($urandom % 65534));
            nr = 1 + ($urandom % MAXR);
            fill(q, 50, nr);
            run_case(q, 1'(t % 2), nr, 1'(($urandom % 2)), "R2 u random");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule